// File: doc/BRIEF.md
# Display Bridge Power-Up Sequencer

This block brings up an external bridge that turns parallel pixel data into a serial display link. When `start` is pulsed, it holds the bridge's reset pin low, then high, for fixed cycle counts. It can then read two registers back over a 24-bit three-wire SPI link to confirm that the link works. After that it writes a fixed, ordered list of configuration registers. Each write is two SPI frames: an index-select frame followed by a value frame. The list loads the display timing, the pixel format, the lane count and a precomputed PLL word. It enables the PLL, sends the display's wake and display-on commands with waits between them, and finally switches the data lanes to high speed and turns on the video path. The caller supplies the PLL word and the low-power clock divider code.

The controller is built around the state type `top_state_t`:
- `T_IDLE`: the state after reset.
- `T_RST_LO` and `T_RST_HI`: the two halves of the bridge reset.
- `T_RD_IDX` and `T_RD_VAL`: one read-back check, done twice.
- `T_WR_IDX` and `T_WR_VAL`: one register write.
- `T_PAUSE`: a wait after the steps that need one.
- `T_DONE` and `T_FAIL`: the two end states.

The transitions are:
- start: from `T_IDLE`, `T_DONE` or `T_FAIL` to `T_RST_LO`.
- reset-low-expired: `T_RST_LO` to `T_RST_HI`.
- reset-high-expired: `T_RST_HI` to `T_RD_IDX` when verification is enabled, otherwise to `T_WR_IDX`.
- read-select-sent: `T_RD_IDX` to `T_RD_VAL`.
- readback-ok: `T_RD_VAL` to `T_RD_IDX` after the first check, or to `T_WR_IDX` after the second.
- readback-bad: `T_RD_VAL` to `T_FAIL`.
- write-select-sent: `T_WR_IDX` to `T_WR_VAL`.
- write-complete: `T_WR_VAL` to `T_PAUSE`, `T_WR_IDX` or `T_DONE`.
- pause-expired: `T_PAUSE` to `T_WR_IDX` or `T_DONE`.

The SPI engine `bbs_spi24` has its own states:
- `M_IDLE`: waiting for a frame.
- `M_LEAD`: guard time after chip select falls.
- `M_LOW` and `M_HIGH`: the two halves of each bit.
- `M_TRAIL`: guard time before chip select rises.
- `M_GAP`: guard time after chip select rises.

Top module: `bridge_bringup_seq`

## Requirements
- R1: After `start`, `bridge_rst_n` is low for exactly RST_LOW_CYC cycles and then goes high. Chip select does not fall until at least RST_HIGH_CYC cycles after that rising edge. Chip select is never low while `bridge_rst_n` is low.
- R2: Each SPI frame has exactly 24 bits, sent MSB first. `spi_sdi` changes only while `spi_sck` is low, and the bridge samples it on the rising edge of `spi_sck`. `spi_sck` idles high. Each clock half lasts `half_cyc`+1 cycles, and each chip-select guard lasts `guard_cyc`+1 cycles.
- R3: A register write is one frame `0x70_00_<index>` followed by one frame `0x72_<16-bit value>`. A complete run makes 17 such writes.
- R4: With `verify_en`=1, the block checks two registers in turn. First it sends the select frame `0x70_00_B0` and then the read frame `0x73_0000`. The last 16 bits on `spi_sdo`, each sampled just before a rising `spi_sck`, must equal 0x2828. It then does the same for index 0xB7, whose value must equal 0x0301. A mismatch ends the run in `error` with no writes. With `verify_en`=0, no read frames are sent.
- R5: The first five writes are, in this order:
  - 0xB1 = {vsync, hsync}
  - 0xB2 = {vsync+vback, hsync+hback}, each byte taken modulo 256
  - 0xB3 = {vfront, hfront}
  - 0xB4 = `h_active`
  - 0xB5 = `v_active`
- R6: Next, 0xB6 = 0x0008 OR `pix_fmt`, where the codes are 0 = 16 bpp, 1 = packed 18 bpp, 2 = loose 18 bpp and 3 = 24 bpp. Then 0xDE = `lane_cnt`-1.
- R7: Next, in this order: 0xB7 = 0x0342 (data lanes low-power, clock lane high-speed, command-only packets), 0xBA = `pll_word`, 0xB8 = 0, 0xBB = `lp_div_code`, and 0xB9 = 1.
- R8: After the 0xB9 write, at least PLL_WAIT_CYC cycles pass before the next frame. The block then writes 0xBC = 1 and 0xBF = 0x0011, and waits at least `wait_sleep` cycles. It then writes 0xBC = 1 and 0xBF = 0x0029, and waits at least `wait_on` cycles.
- R9: The last write is 0xB7 = 0x034B (high-speed data lanes and video enabled). After it, `done` rises.
- R10: `busy` is high from the cycle after an accepted `start` until `done` or `error`. A `start` while busy has no effect. `done` and `error` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (ignored while busy) |
| verify_en | input | 1 | Enable the read-back link check |
| hsync_len | input | 8 | Horizontal sync width |
| vsync_len | input | 8 | Vertical sync width |
| hback | input | 8 | Horizontal back margin |
| vback | input | 8 | Vertical back margin |
| hfront | input | 8 | Horizontal front margin |
| vfront | input | 8 | Vertical front margin |
| h_active | input | 16 | Active pixels per line |
| v_active | input | 16 | Active lines per frame |
| pix_fmt | input | 2 | Pixel format code |
| lane_cnt | input | 3 | Number of data lanes, 1 to 4 |
| pll_word | input | 16 | Precomputed PLL configuration value |
| lp_div_code | input | 6 | Low-power clock divider code |
| half_cyc | input | DW | Extra cycles per SPI clock half |
| guard_cyc | input | DW | Extra cycles per chip-select guard |
| wait_sleep | input | TW | Minimum wait after the wake command |
| wait_on | input | TW | Minimum wait after the display-on command |
| spi_sdo | input | 1 | Serial data from the bridge |
| bridge_rst_n | output | 1 | Bridge reset, active low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_sdi | output | 1 | Serial data to the bridge |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished successfully |
| error | output | 1 | Read-back check failed |

## Verification
The bench measures the exact width of the bridge reset pulse on a second run, when the pin starts high. A design that counted one cycle too few or too many, or that let SPI start before the high-time guard, would be caught there. It decodes every frame with a bus-level slave model. A wrong write order, a wrong byte packing in the timing registers, the wrong format or lane encoding, or a skipped DCS packet-size write would show up as a mismatched log entry. Read-back is tested with a wrong identification value and with a wrong configuration value. A design that ignored either check, or wrote registers after failing, would end in `done` or leave writes in the log. A second `start` is pulsed in the middle of a run. A design that restarted would repeat the early writes and lengthen the log.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [3:0] {
        T_IDLE, T_RST_LO, T_RST_HI, T_RD_IDX, T_RD_VAL,
        T_WR_IDX, T_WR_VAL, T_PAUSE, T_DONE, T_FAIL
    } top_state_t;

    typedef enum logic [2:0] {
        M_IDLE, M_LEAD, M_LOW, M_HIGH, M_TRAIL, M_GAP
    } spi_state_t;

    typedef enum logic [1:0] {PW_NONE, PW_PLL, PW_SLEEP, PW_ON} pause_t;

    localparam int FRAME_BITS = 24;
    localparam int STEPS      = 17;
    localparam int SW         = $clog2(STEPS);

    localparam logic [7:0]  OP_SEL = 8'h70;
    localparam logic [7:0]  OP_WR  = 8'h72;
    localparam logic [7:0]  OP_RD  = 8'h73;

    localparam logic [15:0] ID_WORD     = 16'h2828;
    localparam logic [15:0] CFG_DEFAULT = 16'h0301;
    localparam logic [15:0] CFG_HS      = 16'h0001;
    localparam logic [15:0] CFG_CKE     = 16'h0002;
    localparam logic [15:0] CFG_VEN     = 16'h0008;
    localparam logic [15:0] CFG_DCS     = 16'h0040;
    localparam logic [15:0] CFG_SETUP   = (CFG_DEFAULT & ~CFG_HS) | CFG_CKE | CFG_DCS;
    localparam logic [15:0] CFG_LIVE    = CFG_SETUP | CFG_HS | CFG_VEN;

    localparam logic [7:0]  DCS_WAKE = 8'h11;
    localparam logic [7:0]  DCS_SHOW = 8'h29;

endpackage

// File: rtl/bbs_spi24.sv
module bbs_spi24
    import bbs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [FRAME_BITS-1:0] word,
    input  logic [DW-1:0]         half_cyc,
    input  logic [DW-1:0]         guard_cyc,
    input  logic                  sdo,
    output logic                  cs_n,
    output logic                  sck,
    output logic                  sdi,
    output logic                  fin,
    output logic [15:0]           rx
);

    localparam int BW = $clog2(FRAME_BITS);

    spi_state_t            st;
    logic [DW-1:0]         cnt;
    logic [BW-1:0]         bitn;
    logic [FRAME_BITS-1:0] sh;
    logic [15:0]           rxs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= M_IDLE;
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            rxs  <= '0;
        end else begin
            unique case (st)
                M_IDLE: if (go) begin
                    sh   <= word;
                    bitn <= BW'(FRAME_BITS - 1);
                    cnt  <= guard_cyc;
                    st   <= M_LEAD;
                end
                M_LEAD: if (cnt == '0) begin
                    cnt <= half_cyc;
                    st  <= M_LOW;
                end else cnt <= cnt - 1'b1;
                M_LOW: if (cnt == '0) begin
                    rxs <= {rxs[14:0], sdo};
                    cnt <= half_cyc;
                    st  <= M_HIGH;
                end else cnt <= cnt - 1'b1;
                M_HIGH: if (cnt == '0) begin
                    if (bitn == '0) begin
                        cnt <= guard_cyc;
                        st  <= M_TRAIL;
                    end else begin
                        bitn <= bitn - 1'b1;
                        sh   <= {sh[FRAME_BITS-2:0], 1'b0};
                        cnt  <= half_cyc;
                        st   <= M_LOW;
                    end
                end else cnt <= cnt - 1'b1;
                M_TRAIL: if (cnt == '0) begin
                    cnt <= guard_cyc;
                    st  <= M_GAP;
                end else cnt <= cnt - 1'b1;
                M_GAP: if (cnt == '0) st <= M_IDLE;
                       else cnt <= cnt - 1'b1;
                default: st <= M_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_n = (st == M_IDLE) || (st == M_GAP);
        sck  = (st != M_LOW);
        sdi  = (st == M_IDLE) ? 1'b1 : sh[FRAME_BITS-1];
        fin  = (st == M_GAP) && (cnt == '0);
        rx   = rxs;
    end

    // R2
    sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !cs_n && $past(sck && !cs_n)) |-> $stable(sdi));

    // R2
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (st == M_IDLE));

endmodule

// File: rtl/bbs_steps.sv
module bbs_steps
    import bbs_pkg::*;
(
    input  logic [SW-1:0] step,
    input  logic [7:0]    hsync_len,
    input  logic [7:0]    vsync_len,
    input  logic [7:0]    hback,
    input  logic [7:0]    vback,
    input  logic [7:0]    hfront,
    input  logic [7:0]    vfront,
    input  logic [15:0]   h_active,
    input  logic [15:0]   v_active,
    input  logic [1:0]    pix_fmt,
    input  logic [2:0]    lane_cnt,
    input  logic [15:0]   pll_word,
    input  logic [5:0]    lp_div_code,
    output logic [7:0]    idx,
    output logic [15:0]   val,
    output pause_t        pw,
    output logic          last
);

    logic [7:0] vsum, hsum;
    logic [2:0] lanes_m1;

    always_comb begin
        vsum     = vsync_len + vback;
        hsum     = hsync_len + hback;
        lanes_m1 = lane_cnt - 3'd1;
        idx  = 8'h00;
        val  = 16'h0000;
        pw   = PW_NONE;
        last = 1'b0;
        unique case (step)
            5'd0:  begin idx = 8'hB1; val = {vsync_len, hsync_len}; end
            5'd1:  begin idx = 8'hB2; val = {vsum, hsum}; end
            5'd2:  begin idx = 8'hB3; val = {vfront, hfront}; end
            5'd3:  begin idx = 8'hB4; val = h_active; end
            5'd4:  begin idx = 8'hB5; val = v_active; end
            5'd5:  begin idx = 8'hB6; val = {12'h000, 2'b10, pix_fmt}; end
            5'd6:  begin idx = 8'hDE; val = {13'h0000, lanes_m1}; end
            5'd7:  begin idx = 8'hB7; val = CFG_SETUP; end
            5'd8:  begin idx = 8'hBA; val = pll_word; end
            5'd9:  begin idx = 8'hB8; val = 16'h0000; end
            5'd10: begin idx = 8'hBB; val = {10'h000, lp_div_code}; end
            5'd11: begin idx = 8'hB9; val = 16'h0001; pw = PW_PLL; end
            5'd12: begin idx = 8'hBC; val = 16'h0001; end
            5'd13: begin idx = 8'hBF; val = {8'h00, DCS_WAKE}; pw = PW_SLEEP; end
            5'd14: begin idx = 8'hBC; val = 16'h0001; end
            5'd15: begin idx = 8'hBF; val = {8'h00, DCS_SHOW}; pw = PW_ON; end
            5'd16: begin idx = 8'hB7; val = CFG_LIVE; last = 1'b1; end
            default: begin idx = 8'h00; val = 16'h0000; last = 1'b1; end
        endcase
    end

endmodule

// File: rtl/bridge_bringup_seq.sv
module bridge_bringup_seq
    import bbs_pkg::*;
#(
    parameter int RST_LOW_CYC  = 1_000_000,
    parameter int RST_HIGH_CYC = 1_000_000,
    parameter int PLL_WAIT_CYC = 50_000,
    parameter int TW           = 32,
    parameter int DW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          verify_en,
    input  logic [7:0]    hsync_len,
    input  logic [7:0]    vsync_len,
    input  logic [7:0]    hback,
    input  logic [7:0]    vback,
    input  logic [7:0]    hfront,
    input  logic [7:0]    vfront,
    input  logic [15:0]   h_active,
    input  logic [15:0]   v_active,
    input  logic [1:0]    pix_fmt,
    input  logic [2:0]    lane_cnt,
    input  logic [15:0]   pll_word,
    input  logic [5:0]    lp_div_code,
    input  logic [DW-1:0] half_cyc,
    input  logic [DW-1:0] guard_cyc,
    input  logic [TW-1:0] wait_sleep,
    input  logic [TW-1:0] wait_on,
    input  logic          spi_sdo,
    output logic          bridge_rst_n,
    output logic          spi_cs_n,
    output logic          spi_sck,
    output logic          spi_sdi,
    output logic          busy,
    output logic          done,
    output logic          error
);

    localparam logic [TW-1:0] LOW_LOAD  = TW'(RST_LOW_CYC - 1);
    localparam logic [TW-1:0] HIGH_LOAD = TW'(RST_HIGH_CYC - 1);
    localparam logic [TW-1:0] PLL_LOAD  = TW'(PLL_WAIT_CYC);

    top_state_t st_q, st_d;
    logic [TW-1:0]         cnt;
    logic [SW-1:0]         step;
    logic                  rd_sel, launched, up_q;
    logic                  go, fin;
    logic [FRAME_BITS-1:0] word;
    logic [15:0]           rx, rd_expect;
    logic [7:0]            s_idx;
    logic [15:0]           s_val;
    pause_t                s_pw;
    logic                  s_last;
    logic [TW-1:0]         pause_len;

    bbs_steps u_steps (
        .step(step), .hsync_len(hsync_len), .vsync_len(vsync_len),
        .hback(hback), .vback(vback), .hfront(hfront), .vfront(vfront),
        .h_active(h_active), .v_active(v_active), .pix_fmt(pix_fmt),
        .lane_cnt(lane_cnt), .pll_word(pll_word), .lp_div_code(lp_div_code),
        .idx(s_idx), .val(s_val), .pw(s_pw), .last(s_last)
    );

    bbs_spi24 #(.DW(DW)) u_spi (
        .clk(clk), .rst_n(rst_n), .go(go), .word(word),
        .half_cyc(half_cyc), .guard_cyc(guard_cyc), .sdo(spi_sdo),
        .cs_n(spi_cs_n), .sck(spi_sck), .sdi(spi_sdi), .fin(fin), .rx(rx)
    );

    always_comb begin
        rd_expect = rd_sel ? CFG_DEFAULT : ID_WORD;
        unique case (s_pw)
            PW_PLL:   pause_len = PLL_LOAD;
            PW_SLEEP: pause_len = wait_sleep;
            PW_ON:    pause_len = wait_on;
            default:  pause_len = '0;
        endcase
        st_d = st_q;
        unique case (st_q)
            T_IDLE, T_DONE, T_FAIL: if (start) st_d = T_RST_LO;
            T_RST_LO: if (cnt == '0) st_d = T_RST_HI;
            T_RST_HI: if (cnt == '0) st_d = verify_en ? T_RD_IDX : T_WR_IDX;
            T_RD_IDX: if (fin) st_d = T_RD_VAL;
            T_RD_VAL: if (fin) begin
                if (rx != rd_expect) st_d = T_FAIL;
                else                 st_d = rd_sel ? T_WR_IDX : T_RD_IDX;
            end
            T_WR_IDX: if (fin) st_d = T_WR_VAL;
            T_WR_VAL: if (fin) begin
                if (s_pw != PW_NONE) st_d = T_PAUSE;
                else                 st_d = s_last ? T_DONE : T_WR_IDX;
            end
            T_PAUSE: if (cnt == '0) st_d = s_last ? T_DONE : T_WR_IDX;
            default: st_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= T_IDLE;
            cnt      <= '0;
            step     <= '0;
            rd_sel   <= 1'b0;
            launched <= 1'b0;
            up_q     <= 1'b0;
        end else begin
            st_q     <= st_d;
            launched <= (st_d == st_q) && (launched || go);
            up_q     <= up_q || (st_d == T_RST_HI);
            if (st_d != st_q) begin
                unique case (st_d)
                    T_RST_LO: cnt <= LOW_LOAD;
                    T_RST_HI: cnt <= HIGH_LOAD;
                    T_PAUSE:  cnt <= pause_len;
                    default:  cnt <= '0;
                endcase
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
            if (st_d == T_RST_LO) begin
                step   <= '0;
                rd_sel <= 1'b0;
            end else begin
                if (st_d == T_WR_IDX && (st_q == T_WR_VAL || st_q == T_PAUSE))
                    step <= step + 1'b1;
                if (st_q == T_RD_VAL && st_d == T_RD_IDX)
                    rd_sel <= 1'b1;
            end
        end
    end

    always_comb begin
        go = !launched && (st_q == T_RD_IDX || st_q == T_RD_VAL ||
                           st_q == T_WR_IDX || st_q == T_WR_VAL);
        unique case (st_q)
            T_RD_IDX: word = {OP_SEL, 8'h00, rd_sel ? 8'hB7 : 8'hB0};
            T_RD_VAL: word = {OP_RD, 16'h0000};
            T_WR_IDX: word = {OP_SEL, 8'h00, s_idx};
            T_WR_VAL: word = {OP_WR, s_val};
            default:  word = '0;
        endcase
        busy         = !(st_q == T_IDLE || st_q == T_DONE || st_q == T_FAIL);
        done         = (st_q == T_DONE);
        error        = (st_q == T_FAIL);
        bridge_rst_n = up_q && (st_q != T_RST_LO);
    end

    // R1
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> bridge_rst_n);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && st_q != T_RST_LO) |=> (st_q != T_RST_LO));

    // R9
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(fin));

    // R4
    fail_needs_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> verify_en);

endmodule

// File: tb/bridge_bringup_seq_test.sv
module bridge_bringup_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int L_CYC = 40;
    localparam int H_CYC = 30;
    localparam int P_CYC = 50;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, verify_en = 1'b0;
    logic [7:0] hsync_len, vsync_len, hback, vback, hfront, vfront;
    logic [15:0] h_active, v_active, pll_word;
    logic [1:0] pix_fmt;
    logic [2:0] lane_cnt;
    logic [5:0] lp_div_code;
    logic [7:0] half_cyc, guard_cyc;
    logic [31:0] wait_sleep, wait_on;
    logic spi_sdo, bridge_rst_n, spi_cs_n, spi_sck, spi_sdi, busy, done, error;

    bridge_bringup_seq #(.RST_LOW_CYC(L_CYC), .RST_HIGH_CYC(H_CYC),
                         .PLL_WAIT_CYC(P_CYC), .TW(32), .DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en),
        .hsync_len(hsync_len), .vsync_len(vsync_len), .hback(hback), .vback(vback),
        .hfront(hfront), .vfront(vfront), .h_active(h_active), .v_active(v_active),
        .pix_fmt(pix_fmt), .lane_cnt(lane_cnt), .pll_word(pll_word),
        .lp_div_code(lp_div_code), .half_cyc(half_cyc), .guard_cyc(guard_cyc),
        .wait_sleep(wait_sleep), .wait_on(wait_on), .spi_sdo(spi_sdo),
        .bridge_rst_n(bridge_rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .busy(busy), .done(done), .error(error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bus-level bridge model
    logic [23:0] sh_in, resp = 24'h0;
    logic [7:0]  cur_idx;
    logic [15:0] id_val, cfg_val;
    int nbits = 0, n_wr = 0, n_rd = 0, bad_frames = 0;
    int cs_fall_cyc = 0, sel_start = 0, first_cs_fall = -1;
    bit in_frame = 0;
    logic [7:0]  log_idx [32];
    logic [15:0] log_val [32];
    int idx_start [32];
    int val_end [32];

    assign spi_sdo = (nbits >= 0 && nbits < 24) ? resp[23 - nbits] : 1'b0;

    always @(negedge spi_cs_n) begin
        in_frame = 1;
        nbits = 0;
        sh_in = '0;
        cs_fall_cyc = cyc;
        if (first_cs_fall < 0) first_cs_fall = cyc;
    end

    always @(posedge spi_sck) if (!spi_cs_n) begin
        sh_in = {sh_in[22:0], spi_sdi};
        nbits++;
    end

    always @(posedge spi_cs_n) if (in_frame) begin
        in_frame = 0;
        if (nbits != 24) bad_frames++;
        case (sh_in[23:16])
            8'h70: begin
                if (sh_in[15:8] != 8'h00) bad_frames++;
                cur_idx = sh_in[7:0];
                sel_start = cs_fall_cyc;
                resp = {8'h00, (cur_idx == 8'hB0) ? id_val :
                               (cur_idx == 8'hB7) ? cfg_val : 16'h0000};
            end
            8'h72: begin
                if (n_wr < 32) begin
                    log_idx[n_wr] = cur_idx;
                    log_val[n_wr] = sh_in[15:0];
                    idx_start[n_wr] = sel_start;
                    val_end[n_wr] = cyc;
                end
                n_wr++;
            end
            8'h73: begin
                if (sh_in[15:0] != 16'h0000) bad_frames++;
                n_rd++;
            end
            default: bad_frames++;
        endcase
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_pair(input int k);
        case (k)
            0:  return {8'hB1, vsync_len, hsync_len};
            1:  return {8'hB2, 8'(vsync_len + vback), 8'(hsync_len + hback)};
            2:  return {8'hB3, vfront, hfront};
            3:  return {8'hB4, h_active};
            4:  return {8'hB5, v_active};
            5:  return {8'hB6, 14'h0002, pix_fmt};
            6:  return {8'hDE, 13'h0000, 3'(lane_cnt - 3'd1)};
            7:  return {8'hB7, 16'h0342};
            8:  return {8'hBA, pll_word};
            9:  return {8'hB8, 16'h0000};
            10: return {8'hBB, 10'h000, lp_div_code};
            11: return {8'hB9, 16'h0001};
            12: return {8'hBC, 16'h0001};
            13: return {8'hBF, 16'h0011};
            14: return {8'hBC, 16'h0001};
            15: return {8'hBF, 16'h0029};
            default: return {8'hB7, 16'h034B};
        endcase
    endfunction

    function automatic string req_of(input int k);
        if (k < 5)  return "R5 timing write";
        if (k < 7)  return "R6 format/lane write";
        if (k < 12) return "R7 config write";
        if (k < 16) return "R8 command write";
        return "R9 final config write";
    endfunction

    task automatic setup(input logic [1:0] fmt, input logic [2:0] lanes, input bit ver, input int seed);
        pix_fmt = fmt; lane_cnt = lanes; verify_en = ver;
        hsync_len = 8'(10 + seed); vsync_len = 8'(3 + seed);
        hback = 8'hF8; vback = 8'(20 + seed);
        hfront = 8'(40 + seed); vfront = 8'(7 + seed);
        h_active = 16'(720 + seed); v_active = 16'(1280 - seed);
        pll_word = 16'h4000 + 16'(seed * 257); lp_div_code = 6'(5 + seed);
        wait_sleep = 32'(60 + seed); wait_on = 32'(25 + seed);
        id_val = 16'h2828; cfg_val = 16'h0301;
    endtask

    task automatic clear_log();
        n_wr = 0; n_rd = 0; bad_frames = 0; first_cs_fall = -1;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        while (!(done || error)) @(negedge clk);
    endtask

    task automatic check_writes();
        chk(n_wr == 17, "R3 write count", 32'(n_wr), 32'd17);
        chk(bad_frames == 0, "R2 frame shape", 32'(bad_frames), 32'd0);
        for (int k = 0; k < 17 && k < n_wr; k++)
            chk({log_idx[k], log_val[k]} == exp_pair(k), req_of(k),
                {8'h00, log_idx[k], log_val[k]}, {8'h00, exp_pair(k)});
        if (n_wr >= 17) begin
            chk(idx_start[12] - val_end[11] >= P_CYC, "R8 pll wait",
                32'(idx_start[12] - val_end[11]), 32'(P_CYC));
            chk(idx_start[14] - val_end[13] >= int'(wait_sleep), "R8 wake wait",
                32'(idx_start[14] - val_end[13]), wait_sleep);
            chk(idx_start[16] - val_end[15] >= int'(wait_on), "R8 on wait",
                32'(idx_start[16] - val_end[15]), wait_on);
        end
    endtask

    task automatic t_reset_state();
        chk(busy == 0, "R10 busy after reset", 32'(busy), 0);
        chk(done == 0 && error == 0, "R10 flags after reset", {done, error}, 0);
        chk(bridge_rst_n == 0, "R1 bridge held in reset", 32'(bridge_rst_n), 0);
        chk(spi_cs_n == 1 && spi_sck == 1, "R2 idle bus", {spi_cs_n, spi_sck}, 32'h3);
    endtask

    task automatic t_full_verify();
        setup(2'd3, 3'd4, 1'b1, 0);
        clear_log();
        pulse_start();
        chk(busy == 1, "R10 busy after start", 32'(busy), 1);
        while (n_wr < 5) @(negedge clk);
        pulse_start();
        wait_end();
        @(negedge clk);
        chk(done == 1 && error == 0, "R9 done after run", {done, error}, 32'h2);
        chk(busy == 0, "R10 busy cleared", 32'(busy), 0);
        chk(n_rd == 2, "R4 two readbacks", 32'(n_rd), 2);
        check_writes();
        repeat (20) @(negedge clk);
        chk(done == 1, "R10 done held", 32'(done), 1);
    endtask

    task automatic t_no_verify_reset_width();
        int lowcnt = 0;
        int rise_cyc;
        setup(2'd1, 3'd2, 1'b0, 3);
        half_cyc = 8'd2; guard_cyc = 8'd1;
        clear_log();
        chk(bridge_rst_n == 1, "R1 pin high before rerun", 32'(bridge_rst_n), 1);
        pulse_start();
        while (!bridge_rst_n) begin
            lowcnt++;
            @(negedge clk);
        end
        rise_cyc = cyc;
        chk(lowcnt == L_CYC, "R1 reset low width", 32'(lowcnt), 32'(L_CYC));
        wait_end();
        chk(first_cs_fall - rise_cyc >= H_CYC, "R1 reset high guard",
            32'(first_cs_fall - rise_cyc), 32'(H_CYC));
        chk(n_rd == 0, "R4 no readback when disabled", 32'(n_rd), 0);
        chk(done == 1, "R9 done without verify", 32'(done), 1);
        check_writes();
        half_cyc = 8'd1; guard_cyc = 8'd3;
    endtask

    task automatic t_bad_id();
        setup(2'd0, 3'd1, 1'b1, 1);
        id_val = 16'h2827;
        clear_log();
        pulse_start();
        wait_end();
        @(negedge clk);
        chk(error == 1 && done == 0, "R4 bad id error", {done, error}, 32'h1);
        chk(n_wr == 0, "R4 no writes after bad id", 32'(n_wr), 0);
        chk(n_rd == 1, "R4 stop after first read", 32'(n_rd), 1);
        repeat (10) @(negedge clk);
        chk(error == 1 && busy == 0, "R10 error held", {busy, error}, 32'h1);
    endtask

    task automatic t_bad_cfg();
        setup(2'd0, 3'd1, 1'b1, 2);
        cfg_val = 16'h0300;
        clear_log();
        pulse_start();
        wait_end();
        @(negedge clk);
        chk(error == 1, "R4 bad config error", 32'(error), 1);
        chk(n_rd == 2 && n_wr == 0, "R4 reads then abort", {16'(n_rd), 16'(n_wr)}, 32'h00020000);
    endtask

    task automatic t_loose18();
        setup(2'd2, 3'd1, 1'b1, 5);
        clear_log();
        pulse_start();
        chk(error == 0, "R10 error cleared by start", 32'(error), 0);
        wait_end();
        @(negedge clk);
        chk(done == 1, "R9 done loose 18", 32'(done), 1);
        check_writes();
    endtask

    initial begin
        half_cyc = 8'd1; guard_cyc = 8'd3;
        setup(2'd3, 3'd4, 1'b1, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_full_verify();
        t_no_verify_reset_width();
        t_bad_id();
        t_bad_cfg();
        t_loose18();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule